// File: doc/BRIEF.md
# Bidirectional Parity Transceiver

An eight-bit bus transceiver that links two data ports and adds a parity generator and checker. A direction input selects the path. In transmit the word on port A is copied to port B. In receive the word on port B is copied to port A. A select input chooses the parity sense: odd or even. In transmit the block drives a shared parity line computed from A. In receive the same line is an input, and the block checks it against B, reporting a mismatch on an active-low error flag.

Each tri-state pin group is modelled as three signals: data in, data out and a per-bit output enable. An active-high disable input releases every driver, including the parity line. Data passes through without inversion. The block holds no state: every output is a pure function of the current inputs.

Top module: `ptx_transceiver`

## Requirements
- R1: With `dir_tx`=1 and `hold_off`=0, `b_out` equals `a_in` bit for bit, every bit of `b_oe` is 1 and every bit of `a_oe` is 0.
- R2: With `dir_tx`=0 and `hold_off`=0, `a_out` equals `b_in` bit for bit, every bit of `a_oe` is 1 and every bit of `b_oe` is 0.
- R3: With `hold_off`=1, every bit of `a_oe` and `b_oe` is 0 and `par_oe` is 0, whatever the other inputs are.
- R4: In transmit (`dir_tx`=1), `par_out` is chosen so that the number of ones over `a_in` plus `par_out` is odd when `odd_sel`=1 and even when `odd_sel`=0. For example, even sense with five A bits high gives `par_out`=1.
- R5: `par_oe` is 1 exactly when `dir_tx`=1 and `hold_off`=0.
- R6: With `dir_tx`=0 and `hold_off`=0, `err_n` is 1 when the number of ones over `b_in` plus `par_in` has the selected sense (odd for `odd_sel`=1, even for `odd_sel`=0), and 0 otherwise. For example, odd sense with `par_in`=1 and three B bits high gives `err_n`=0.
- R7: In transmit, or whenever `hold_off`=1, `err_n` is 1, and `par_in` has no effect on it.

Ports are listed in declaration order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dir_tx | input | 1 | 1: transmit A to B, 0: receive B to A |
| hold_off | input | 1 | 1: release all port drivers |
| odd_sel | input | 1 | 1: odd parity sense, 0: even |
| a_in | input | 8 | Port A pin levels |
| a_out | output | 8 | Port A drive value |
| a_oe | output | 8 | Port A per-bit drive enable |
| b_in | input | 8 | Port B pin levels |
| b_out | output | 8 | Port B drive value |
| b_oe | output | 8 | Port B per-bit drive enable |
| par_in | input | 1 | Parity pin level (receive) |
| par_out | output | 1 | Parity drive value (transmit) |
| par_oe | output | 1 | Parity pin drive enable |
| err_n | output | 1 | Active-low parity mismatch flag |

## Verification
Every output of the block is due in the same cycle as its stimulus, with no register on any path. The driver applies one input set just after a rising clock edge and queues the expected outputs. The monitor pops and compares them at the following falling edge, half a period later, so the combinational logic has settled and no comparison depends on process order at an edge. The sweep covers both directions, both disable levels, both parity senses, all 256 data words and both parity-pin levels.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  // Direction of the data path.
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // Bit to append so that a word whose ones-count oddness is word_odd
  // reaches the requested sense (want_odd = 1 means odd total).
  function automatic logic fill_bit(input logic word_odd, input logic want_odd);
    return word_odd ^ want_odd;
  endfunction

  // True when a total with oddness total_odd meets the requested sense.
  function automatic logic sense_met(input logic total_odd, input logic want_odd);
    return total_odd == want_odd;
  endfunction

endpackage

// File: rtl/ptx_xor_tree.sv
module ptx_xor_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  output logic         odd
);
  logic [W:0] chain;

  assign chain[0] = 1'b0;

  generate
    for (genvar i = 0; i < W; i++) begin : g_stage
      assign chain[i+1] = chain[i] ^ d[i];
    end
  endgenerate

  assign odd = chain[W];
endmodule

// File: rtl/ptx_dir_ctrl.sv
module ptx_dir_ctrl
  import ptx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         dir_tx,
  input  logic         hold_off,
  output logic         tx_active,
  output logic         rx_active,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe,
  output logic         par_oe
);
  dir_e mode;

  assign mode      = dir_e'(dir_tx);
  assign tx_active = (mode == DIR_TX) && !hold_off;
  assign rx_active = (mode == DIR_RX) && !hold_off;

  generate
    for (genvar i = 0; i < W; i++) begin : g_oe
      assign b_oe[i] = tx_active;
      assign a_oe[i] = rx_active;
    end
  endgenerate

  assign par_oe = tx_active;
endmodule

// File: rtl/ptx_parity_unit.sv
module ptx_parity_unit
  import ptx_pkg::*;
(
  input  logic rx_active,
  input  logic odd_sel,
  input  logic a_odd,
  input  logic b_odd,
  input  logic par_in,
  output logic par_out,
  output logic err_n
);
  logic rx_total_odd;
  logic rx_ok;

  assign par_out      = fill_bit(a_odd, odd_sel);
  assign rx_total_odd = b_odd ^ par_in;
  assign rx_ok        = sense_met(rx_total_odd, odd_sel);
  assign err_n        = rx_active ? rx_ok : 1'b1;
endmodule

// File: rtl/ptx_transceiver.sv
module ptx_transceiver #(
  parameter int W = 8
) (
  input  logic         dir_tx,
  input  logic         hold_off,
  input  logic         odd_sel,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         par_in,
  output logic         par_out,
  output logic         par_oe,
  output logic         err_n
);
  // Internal events brought out for the checker.
  logic tx_active;
  logic rx_active;
  logic a_odd;
  logic b_odd;

  ptx_xor_tree #(.W(W)) u_a_tree (.d(a_in), .odd(a_odd));
  ptx_xor_tree #(.W(W)) u_b_tree (.d(b_in), .odd(b_odd));

  ptx_dir_ctrl #(.W(W)) u_dir (
    .dir_tx    (dir_tx),
    .hold_off  (hold_off),
    .tx_active (tx_active),
    .rx_active (rx_active),
    .a_oe      (a_oe),
    .b_oe      (b_oe),
    .par_oe    (par_oe)
  );

  ptx_parity_unit u_par (
    .rx_active (rx_active),
    .odd_sel   (odd_sel),
    .a_odd     (a_odd),
    .b_odd     (b_odd),
    .par_in    (par_in),
    .par_out   (par_out),
    .err_n     (err_n)
  );

  // Non-inverting copy; the enables decide which side drives.
  assign b_out = a_in;
  assign a_out = b_in;
endmodule

// File: rtl/ptx_checker.sv
module ptx_checker #(
  parameter int W = 8
) (
  input logic         dir_tx,
  input logic         hold_off,
  input logic         odd_sel,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic         par_in,
  input logic         par_out,
  input logic         par_oe,
  input logic         err_n,
  input logic         tx_active,
  input logic         rx_active
);
  always_comb begin
    // R1
    tx_route_chk: assert (!(dir_tx && !hold_off) ||
                          (b_out == a_in && &b_oe && a_oe == '0));
    // R2
    rx_route_chk: assert (!(!dir_tx && !hold_off) ||
                          (a_out == b_in && &a_oe && b_oe == '0));
    // R3
    release_all_chk: assert (!hold_off || (a_oe == '0 && b_oe == '0 && !par_oe));
    // R4
    tx_sense_chk: assert (!dir_tx || (($countones({a_in, par_out}) % 2) == int'(odd_sel)));
    // R5
    par_drive_chk: assert (par_oe == tx_active);
    // R6
    rx_err_chk: assert (!rx_active ||
                        (err_n == (($countones({b_in, par_in}) % 2) == int'(odd_sel))));
    // R7
    err_quiet_chk: assert (rx_active || err_n);
    // R1
    one_side_chk: assert ($onehot0({|a_oe, |b_oe}));
  end
endmodule

bind ptx_transceiver ptx_checker #(.W(W)) u_chk (
  .dir_tx    (dir_tx),
  .hold_off  (hold_off),
  .odd_sel   (odd_sel),
  .a_in      (a_in),
  .a_out     (a_out),
  .a_oe      (a_oe),
  .b_in      (b_in),
  .b_out     (b_out),
  .b_oe      (b_oe),
  .par_in    (par_in),
  .par_out   (par_out),
  .par_oe    (par_oe),
  .err_n     (err_n),
  .tx_active (tx_active),
  .rx_active (rx_active)
);

// File: tb/test_ptx_transceiver.sv
module test_ptx_transceiver;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         dir_tx = 1'b0, hold_off = 1'b0, odd_sel = 1'b0, par_in = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic         par_out, par_oe, err_n;

  ptx_transceiver #(.W(W)) i_ptx_transceiver (
    .dir_tx(dir_tx), .hold_off(hold_off), .odd_sel(odd_sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .err_n(err_n)
  );

  typedef struct {
    logic         tx_on;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         par_out, par_oe, err_n;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: apply one input set and queue its expected outputs.
  task automatic drive(input logic d, input logic h, input logic s,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
    exp_t e;
    int   ones_a, ones_b;
    bit   tx_on, rx_on;
    @(posedge clk);
    #1;
    dir_tx = d; hold_off = h; odd_sel = s; a_in = a; b_in = b; par_in = p;
    ones_a = 0; ones_b = 0;
    for (int i = 0; i < W; i++) begin
      ones_a += int'(a[i]);
      ones_b += int'(b[i]);
    end
    tx_on = d && !h;
    rx_on = !d && !h;
    e.tx_on   = d;
    e.a_out   = b;
    e.b_out   = a;
    e.a_oe    = rx_on ? '1 : '0;
    e.b_oe    = tx_on ? '1 : '0;
    e.par_oe  = tx_on;
    // odd total wanted when s=1: add 1 if count parity differs from wanted.
    e.par_out = ((ones_a % 2) == 1) != s;
    if (rx_on) e.err_n = (((ones_b + int'(p)) % 2) == 1) == s;
    else       e.err_n = 1'b1;
    q.push_back(e);
  endtask

  // Monitor: compare at the falling edge, half a period after the drive.
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(a_oe == e.a_oe, "R2/R3 a_oe", int'(a_oe), int'(e.a_oe));
      chk(b_oe == e.b_oe, "R1/R3 b_oe", int'(b_oe), int'(e.b_oe));
      chk(par_oe == e.par_oe, "R5 par_oe", int'(par_oe), int'(e.par_oe));
      chk(err_n == e.err_n, "R6/R7 err_n", int'(err_n), int'(e.err_n));
      if (e.b_oe != '0) chk(b_out == e.b_out, "R1 b_out", int'(b_out), int'(e.b_out));
      if (e.a_oe != '0) chk(a_out == e.a_out, "R2 a_out", int'(a_out), int'(e.a_out));
      if (e.tx_on) chk(par_out == e.par_out, "R4 par_out", int'(par_out), int'(e.par_out));
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset-state inputs: receive, enabled, even, all zero (R2, R6).
    drive(1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
    // R4 example: even sense, five A bits high -> parity 1.
    drive(1'b1, 1'b0, 1'b0, 8'h1F, 8'h00, 1'b0);
    // R6 example: odd sense, parity 1, three B bits high -> err_n 0.
    drive(1'b0, 1'b0, 1'b1, 8'h00, 8'h07, 1'b1);
    // R3 / R7: disabled, par_in toggled must not matter.
    drive(1'b0, 1'b1, 1'b1, 8'hA5, 8'h07, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 8'hA5, 8'h07, 1'b0);
    // Full sweep: R1..R7 over all controls, words and parity levels.
    for (int d = 0; d < 2; d++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < 2; s++)
          for (int v = 0; v < 256; v++)
            for (int p = 0; p < 2; p++)
              drive(d[0], h[0], s[0], v[W-1:0], ~v[W-1:0] ^ 8'h3C, p[0]);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule